// File: doc/BRIEF.md
# GPIO Port Controller with Edge Interrupts

This block controls a 32-pin general-purpose I/O port through a plain register bus. For each pin it holds six control bits: whether the GPIO logic or a peripheral owns the pin, output drive enable, output level, pull-up enable, pull-down enable and input Schmitt-trigger enable. Every control register has write-one set and write-one clear aliases, so software changes single bits without reading first. The output level register also has a direct-write alias and a toggle alias.

Pad inputs pass through a two-flop synchronizer. The synchronized value can be read back as the pin value register. The synchronized value also feeds an edge detector. Two mode bit-planes pick any edge, rising only or falling only for each pin. A detected edge on a pin whose interrupt enable is set latches a sticky flag. Software clears the flag by writing 1 to the flag clear alias. Four interrupt request lines each OR the enabled, pending flags of one group of eight pins.

The bus has no handshake and never stalls. A write takes effect at the clock edge where `bus_en` and `bus_we` are high. A read presents its data on `bus_rdata` one cycle after the request, and `bus_rdata` holds that value until the next read.

Top module: `gpio_port`

## Requirements
- R1: After reset, all control registers, mode bits and flags are 0. `pad_do`, `pad_oe`, `pad_pu`, `pad_pd`, `pad_st`, `pin_gpio` and `irq` are therefore 0.
- R2: The word address is {index[3:0], alias[1:0]}, with alias 1 = set and alias 2 = clear. The registers with these aliases are output level (index 0), output enable (1), ownership (2), pull-up (3), pull-down (4), Schmitt (5), interrupt enable (6), mode bit 0 (7) and mode bit 1 (8). On a set or clear write, each bit written as 1 is set or cleared, and each bit written as 0 keeps its value.
- R3: For the output level register only, alias 0 replaces all 32 bits and alias 3 inverts each bit written as 1.
- R4: `pad_oe` is output enable AND ownership. `pin_gpio` is the ownership register. `pad_do`, `pad_pu`, `pad_pd` and `pad_st` show their registers directly.
- R5: The pin value register (index 10) is the pad input after two flops. A pad change made before clock edge k is readable from a read issued after edge k+2, and is not returned by a read sampled at edge k+1.
- R6: Edge selection uses the mode bits of the pin. With both mode bits 0, any edge is selected. With only mode bit 0 set, rising edges only. With only mode bit 1 set, falling edges only. With both bits set, any edge.
- R7: A flag bit is set only by a selected edge on a pin whose interrupt enable is 1 at detection. Edges seen while the enable is 0 are not latched later. A flag goes high on the third clock edge after the pad change.
- R8: Flags (read at index 10 − 1 = 9) stay set until a write to index 9, alias 2 has 1 in that bit position. Other bits of that write, and other writes, leave flags unchanged.
- R9: irq[g] is the OR over pins 8g..8g+7 of flag AND interrupt enable. Clearing the enable drops the request while the flag stays pending.
- R10: Writes that are not listed above have no effect on any register. This covers alias 0 or 3 to indexes 1–8, any alias to the pin value register, and aliases 0, 1 or 3 to the flag register.
- R11: Reading an index from 11 to 15 returns 0. Reading indexes 0–8 returns the register value under any alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Word address {index, alias} |
| bus_wdata | input | 32 | Write data / bit mask |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_do | output | 32 | Output level to the pads |
| pad_oe | output | 32 | Output driver enable to the pads |
| pad_pu | output | 32 | Pull-up enable |
| pad_pd | output | 32 | Pull-down enable |
| pad_st | output | 32 | Schmitt-trigger enable |
| pin_gpio | output | 32 | 1 = pin owned by GPIO, 0 = peripheral |
| irq | output | 4 | Interrupt request per 8-pin group |

## Verification
The hardest thing to show from the ports is that edge polarity is decoded correctly for every mode pattern. This matters because a flag appears only three clock edges after a pad change, and a flag caused by one edge can hide the absence of another.

The stimulus sets four pins to the four mode patterns and raises all four pads together. It reads the flag vector and clears it, then lowers the pads and reads again. The two flag vectors must differ exactly as the polarity rules say.

A second scenario changes a pad while its interrupt enable is 0, then turns the enable on. This shows that a missed edge is never latched late. The group test clears an enable under a pending flag to separate the request from the flag.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 6;
  localparam int NCTL   = 9;

  typedef enum logic [1:0] {
    AL_DIRECT = 2'd0,
    AL_SET    = 2'd1,
    AL_CLR    = 2'd2,
    AL_TGL    = 2'd3
  } alias_e;

  localparam logic [3:0] IX_OUT  = 4'd0;
  localparam logic [3:0] IX_OE   = 4'd1;
  localparam logic [3:0] IX_OWN  = 4'd2;
  localparam logic [3:0] IX_PU   = 4'd3;
  localparam logic [3:0] IX_PD   = 4'd4;
  localparam logic [3:0] IX_ST   = 4'd5;
  localparam logic [3:0] IX_IEN  = 4'd6;
  localparam logic [3:0] IX_M0   = 4'd7;
  localparam logic [3:0] IX_M1   = 4'd8;
  localparam logic [3:0] IX_FLAG = 4'd9;
  localparam logic [3:0] IX_PIN  = 4'd10;
endpackage

// File: rtl/gpio_ctl_reg.sv
module gpio_ctl_reg
  import gpio_port_pkg::*;
#(
  parameter int W    = 32,
  parameter bit FULL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  alias_e       alias_sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_en) begin
      case (alias_sel)
        AL_SET:    q <= q | wdata;
        AL_CLR:    q <= q & ~wdata;
        AL_DIRECT: if (FULL) q <= wdata;
        AL_TGL:    if (FULL) q <= q ^ wdata;
        default:   q <= q;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage1 <= '0;
      q_sync <= '0;
    end else begin
      stage1 <= d_async;
      q_sync <= stage1;
    end
  end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int N_PINS = 32,
  parameter int N_GRP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_s,
  input  logic [N_PINS-1:0] ien,
  input  logic [N_PINS-1:0] mode0,
  input  logic [N_PINS-1:0] mode1,
  input  logic [N_PINS-1:0] clr_mask,
  output logic [N_PINS-1:0] flags,
  output logic [N_GRP-1:0]  irq
);
  localparam int GRP_SZ = N_PINS / N_GRP;

  logic [N_PINS-1:0] prev_s;
  logic [N_PINS-1:0] rise, fall, any_sel, hit;

  always_comb begin
    rise    = pin_s & ~prev_s;
    fall    = ~pin_s & prev_s;
    any_sel = ~(mode0 ^ mode1);
    hit     = ien & ((any_sel & (rise | fall)) |
                     (mode0 & ~mode1 & rise) |
                     (mode1 & ~mode0 & fall));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_s <= '0;
      flags  <= '0;
    end else begin
      prev_s <= pin_s;
      flags  <= (flags & ~clr_mask) | hit;
    end
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    assign irq[g] = |(flags[g*GRP_SZ +: GRP_SZ] & ien[g*GRP_SZ +: GRP_SZ]);
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int N_GRP  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [N_PINS-1:0] bus_wdata,
  output logic [N_PINS-1:0] bus_rdata,
  input  logic [N_PINS-1:0] pad_in,
  output logic [N_PINS-1:0] pad_do,
  output logic [N_PINS-1:0] pad_oe,
  output logic [N_PINS-1:0] pad_pu,
  output logic [N_PINS-1:0] pad_pd,
  output logic [N_PINS-1:0] pad_st,
  output logic [N_PINS-1:0] pin_gpio,
  output logic [N_GRP-1:0]  irq
);
  logic              wr;
  logic [3:0]        idx;
  alias_e            al;
  logic [N_PINS-1:0] ctl_q [NCTL];
  logic [N_PINS-1:0] out_q, oe_q, own_q, ien_q, m0_q, m1_q;
  logic [N_PINS-1:0] pin_s, flag_q, clr_mask, rd_nx;

  assign wr  = bus_en && bus_we;
  assign idx = bus_addr[ADDR_W-1:2];
  assign al  = alias_e'(bus_addr[1:0]);

  for (genvar i = 0; i < NCTL; i++) begin : g_ctl
    gpio_ctl_reg #(
      .W    (N_PINS),
      .FULL (i == int'(IX_OUT))
    ) u_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr && (idx == 4'(i))),
      .alias_sel (al),
      .wdata     (bus_wdata),
      .q         (ctl_q[i])
    );
  end

  assign out_q = ctl_q[IX_OUT];
  assign oe_q  = ctl_q[IX_OE];
  assign own_q = ctl_q[IX_OWN];
  assign ien_q = ctl_q[IX_IEN];
  assign m0_q  = ctl_q[IX_M0];
  assign m1_q  = ctl_q[IX_M1];

  assign pad_do   = out_q;
  assign pad_oe   = oe_q & own_q;
  assign pad_pu   = ctl_q[IX_PU];
  assign pad_pd   = ctl_q[IX_PD];
  assign pad_st   = ctl_q[IX_ST];
  assign pin_gpio = own_q;

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (pad_in),
    .q_sync  (pin_s)
  );

  assign clr_mask = (wr && idx == IX_FLAG && al == AL_CLR) ? bus_wdata : '0;

  gpio_edge_irq #(.N_PINS(N_PINS), .N_GRP(N_GRP)) u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .ien      (ien_q),
    .mode0    (m0_q),
    .mode1    (m1_q),
    .clr_mask (clr_mask),
    .flags    (flag_q),
    .irq      (irq)
  );

  always_comb begin
    rd_nx = '0;
    for (int k = 0; k < NCTL; k++) begin
      if (idx == 4'(k)) rd_nx = ctl_q[k];
    end
    if (idx == IX_FLAG) rd_nx = flag_q;
    if (idx == IX_PIN)  rd_nx = pin_s;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                bus_rdata <= '0;
    else if (bus_en && !bus_we) bus_rdata <= rd_nx;
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int N_PINS = 32,
  parameter int N_GRP  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_PINS-1:0] bus_wdata,
  input logic [N_PINS-1:0] pad_oe,
  input logic [N_PINS-1:0] pin_gpio,
  input logic [N_PINS-1:0] pad_do,
  input logic [N_PINS-1:0] flags,
  input logic [N_PINS-1:0] ien,
  input logic [N_GRP-1:0]  irq
);
  localparam int GRP_SZ = N_PINS / N_GRP;

  logic              set_out_wr, clr_out_wr;
  logic [N_PINS-1:0] flag_clr;

  assign set_out_wr = bus_en && bus_we && bus_addr == {IX_OUT, AL_SET};
  assign clr_out_wr = bus_en && bus_we && bus_addr == {IX_OUT, AL_CLR};
  assign flag_clr   = (bus_en && bus_we && bus_addr == {IX_FLAG, AL_CLR}) ? bus_wdata : '0;

  p_drive_needs_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & ~pin_gpio) == '0);

  p_set_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    set_out_wr |=> ((pad_do & $past(bus_wdata)) == $past(bus_wdata)));

  p_clear_alias_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_out_wr |=> ((pad_do & $past(bus_wdata)) == '0));

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flags) & ~$past(flag_clr)) & ~flags) == '0);

  p_flag_needs_ien_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & ~$past(flags) & ~$past(ien)) == '0);

  for (genvar g = 0; g < N_GRP; g++) begin : g_irq
    p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> (|flags[g*GRP_SZ +: GRP_SZ]));
  end
endmodule

bind gpio_port gpio_port_chk #(.N_PINS(N_PINS), .N_GRP(N_GRP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_oe    (pad_oe),
  .pin_gpio  (pin_gpio),
  .pad_do    (pad_do),
  .flags     (flag_q),
  .ien       (ien_q),
  .irq       (irq)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int CLK_PERIOD = 10;

  localparam int I_OUT = 0, I_OE = 1, I_OWN = 2, I_PU = 3, I_PD = 4, I_ST = 5;
  localparam int I_IEN = 6, I_M0 = 7, I_M1 = 8, I_FLAG = 9, I_PIN = 10;
  localparam int A_DIR = 0, A_SET = 1, A_CLR = 2, A_TGL = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_do, pad_oe, pad_pu, pad_pd, pad_st, pin_gpio;
  logic [3:0]  irq;

  int n_total = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_do(pad_do), .pad_oe(pad_oe), .pad_pu(pad_pu),
    .pad_pd(pad_pd), .pad_st(pad_st), .pin_gpio(pin_gpio), .irq(irq)
  );

  function automatic logic [5:0] ad(int ix, int al);
    return 6'(ix * 4 + al);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int ix, int al, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ad(ix, al); bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(int ix, int al, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ad(ix, al);
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 pad_do", pad_do, '0);
    chk("R1 pad_oe", pad_oe, '0);
    chk("R1 pin_gpio", pin_gpio, '0);
    chk("R1 pulls", pad_pu | pad_pd | pad_st, '0);
    chk("R1 irq", 32'(irq), '0);
    for (int i = 0; i <= I_FLAG; i++) begin
      rd(i, A_DIR, v);
      chk("R1 reg read", v, '0);
    end
  endtask

  task automatic t_out_aliases();
    logic [31:0] v;
    wr(I_OUT, A_DIR, 32'h1234_5678);
    chk("R3 direct write", pad_do, 32'h1234_5678);
    wr(I_OUT, A_SET, 32'h0000_000F);
    chk("R2 set out", pad_do, 32'h1234_567F);
    wr(I_OUT, A_CLR, 32'h1200_0000);
    chk("R2 clear out", pad_do, 32'h0034_567F);
    wr(I_OUT, A_TGL, 32'hFFFF_0000);
    chk("R3 toggle out", pad_do, 32'hFFCB_567F);
    rd(I_OUT, A_TGL, v);
    chk("R11 read via alias", v, 32'hFFCB_567F);
    wr(I_OUT, A_SET, 32'h0);
    chk("R2 zero mask set", pad_do, 32'hFFCB_567F);
  endtask

  task automatic t_pad_ctl();
    wr(I_PU, A_SET, 32'h0000_00F0);
    wr(I_PU, A_CLR, 32'h0000_0030);
    chk("R2 pull-up", pad_pu, 32'h0000_00C0);
    wr(I_PD, A_SET, 32'h8000_0001);
    chk("R2 pull-down", pad_pd, 32'h8000_0001);
    wr(I_ST, A_SET, 32'hFFFF_FFFF);
    wr(I_ST, A_CLR, 32'h0F0F_0F0F);
    chk("R2 schmitt", pad_st, 32'hF0F0_F0F0);
    wr(I_OE, A_SET, 32'h0000_0003);
    chk("R4 oe without ownership", pad_oe, 32'h0);
    wr(I_OWN, A_SET, 32'h0000_0006);
    chk("R4 oe and ownership", pad_oe, 32'h0000_0002);
    chk("R4 pin_gpio", pin_gpio, 32'h0000_0006);
  endtask

  task automatic t_ignored_writes();
    logic [31:0] v;
    wr(I_OE, A_DIR, 32'hFFFF_FFFF);
    wr(I_OE, A_TGL, 32'hFFFF_FFFF);
    chk("R10 oe direct/toggle ignored", pad_oe, 32'h0000_0002);
    rd(I_OE, A_DIR, v);
    chk("R10 oe register kept", v, 32'h0000_0003);
    wr(I_PIN, A_SET, 32'hFFFF_FFFF);
    rd(I_PIN, A_DIR, v);
    chk("R10 pin value not writable", v, 32'h0);
    wr(I_FLAG, A_SET, 32'hFFFF_FFFF);
    wr(I_FLAG, A_DIR, 32'hFFFF_FFFF);
    rd(I_FLAG, A_DIR, v);
    chk("R10 flags not settable", v, 32'h0);
    rd(12, A_DIR, v);
    chk("R11 unmapped read", v, 32'h0);
  endtask

  task automatic t_pin_value();
    logic [31:0] v;
    @(negedge clk);
    pad_in = 32'hA5A5_0000;
    rd(I_PIN, A_DIR, v);
    chk("R5 not visible after one edge", v, 32'h0);
    rd(I_PIN, A_DIR, v);
    chk("R5 visible after two edges", v, 32'hA5A5_0000);
    @(negedge clk);
    pad_in = 32'h0;
    settle();
  endtask

  task automatic t_edge_modes();
    logic [31:0] v;
    wr(I_M0, A_SET, 32'hA);
    wr(I_M1, A_SET, 32'hC);
    wr(I_IEN, A_SET, 32'hF);
    @(negedge clk);
    pad_in[3:0] = 4'hF;
    @(negedge clk);
    @(negedge clk);
    chk("R7 no flag before third edge", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R7 flag on third edge", 32'(irq), 32'h1);
    settle();
    rd(I_FLAG, A_DIR, v);
    chk("R6 rising edge flags", v, 32'hB);
    wr(I_FLAG, A_CLR, 32'hF);
    @(negedge clk);
    pad_in[3:0] = 4'h0;
    settle();
    rd(I_FLAG, A_DIR, v);
    chk("R6 falling edge flags", v, 32'hD);
    wr(I_FLAG, A_CLR, 32'h2);
    rd(I_FLAG, A_DIR, v);
    chk("R8 clear of unset bit keeps others", v, 32'hD);
    repeat (20) @(negedge clk);
    rd(I_FLAG, A_DIR, v);
    chk("R8 flags stay pending", v, 32'hD);
    wr(I_FLAG, A_CLR, 32'h1);
    rd(I_FLAG, A_DIR, v);
    chk("R8 partial clear", v, 32'hC);
    wr(I_FLAG, A_CLR, 32'hF);
    rd(I_FLAG, A_DIR, v);
    chk("R8 full clear", v, 32'h0);
    wr(I_M0, A_CLR, 32'hF);
    wr(I_M1, A_CLR, 32'hF);
    wr(I_IEN, A_CLR, 32'hF);
  endtask

  task automatic t_enable_gate();
    logic [31:0] v;
    @(negedge clk);
    pad_in[4] = 1'b1;
    settle();
    wr(I_IEN, A_SET, 32'h10);
    settle();
    rd(I_FLAG, A_DIR, v);
    chk("R7 disabled edge not latched", v, 32'h0);
    chk("R7 irq stays low", 32'(irq), 32'h0);
    wr(I_IEN, A_CLR, 32'h10);
    @(negedge clk);
    pad_in[4] = 1'b0;
    settle();
  endtask

  task automatic t_groups();
    logic [31:0] v;
    wr(I_IEN, A_SET, 32'h0101_0101);
    @(negedge clk);
    pad_in[9] = 1'b1;
    settle();
    chk("R9 disabled pin no request", 32'(irq), 32'h0);
    @(negedge clk);
    pad_in[16] = 1'b1;
    settle();
    chk("R9 group 2 request", 32'(irq), 32'h4);
    @(negedge clk);
    pad_in[31] = 1'b1;
    pad_in[24] = 1'b1;
    settle();
    chk("R9 groups 2 and 3", 32'(irq), 32'hC);
    wr(I_IEN, A_CLR, 32'h0001_0000);
    chk("R9 enable masks request", 32'(irq), 32'h8);
    rd(I_FLAG, A_DIR, v);
    chk("R9 flag still pending", v, 32'h0101_0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_out_aliases();
    t_pad_ctl();
    t_ignored_writes();
    t_pin_value();
    t_edge_modes();
    t_enable_gate();
    t_groups();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule